// File: doc/BRIEF.md
# Burst Address Generator

This block sits in front of a synchronous memory core and supplies the address the core uses on each cycle. A burst opens when either of two active-low address strobes is asserted. The block then registers the full start address and clears a small beat counter. Each later cycle with the active-low advance input asserted moves the counter one step. Only the lowest counter-width address bits follow the counter. The upper bits keep the value that was loaded.

A static order input picks how the counter is applied to the loaded low bits. High selects interleaved order: the low bits are XORed with the counter. Low selects linear order: the counter is added modulo four, so the burst wraps inside its aligned group of four. The processor strobe only counts while the primary chip enable is asserted (low). The controller strobe always counts. A strobe takes priority over the advance input. When nothing is asserted, the address holds.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `addr_out` is all zeros.
- R2: A low `strobe_ctrl_n` at a rising edge loads `addr_in` whatever `chip_en_n` is. After that edge `addr_out` equals the loaded address, because the counter is cleared.
- R3: A low `strobe_proc_n` at a rising edge loads `addr_in` in the same way, provided `chip_en_n` is low at that edge.
- R4: A low `strobe_proc_n` is ignored while `chip_en_n` is high. With `adv_n` high as well, `addr_out` stays unchanged.
- R5: With `order_sel` high (interleaved), after n advances `addr_out[1:0]` equals the loaded bits [1:0] XOR (n mod 4).
- R6: With `order_sel` low (linear), after n advances `addr_out[1:0]` equals (loaded bits [1:0] + n) mod 4.
- R7: During a burst, `addr_out[16:2]` keeps the loaded value until the next load.
- R8: After four advances the counter wraps, and `addr_out` again equals the loaded start address.
- R9: A strobe that is accepted in the same cycle as a low `adv_n` reloads the address and clears the counter. The advance is discarded.
- R10: When no strobe is accepted and `adv_n` is high, `addr_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | 17 | Start address presented with a strobe |
| strobe_proc_n | input | 1 | Processor address strobe, active low, gated by chip_en_n |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low, never gated |
| chip_en_n | input | 1 | Primary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order; held static |
| addr_out | output | 17 | Current address for the memory core |

## Verification
Each result arrives one clock after the edge that samples its stimulus. A load, an advance or a hold is decided at a rising edge. It reaches `addr_out` through the base and counter registers plus the combinational order map, with no further delay. The bench drives inputs two time units after a rising edge and samples `addr_out` just after the next one, so every check sees exactly one registered step. The sweep covers every start value of the low bits under both orders, with four advances and the wrap.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int DEF_ADDR_W = 17;
    localparam int DEF_CNT_W  = 2;

    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic load;
        logic step;
    } burst_cmd_t;

    function automatic burst_cmd_t decode_cmd(
        input logic proc_n,
        input logic ctrl_n,
        input logic ce_n,
        input logic adv_n
    );
        burst_cmd_t c;
        c.load = (!proc_n && !ce_n) || !ctrl_n;
        c.step = !c.load && !adv_n;
        return c;
    endfunction

endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
    import burst_pkg::*;
(
    input  logic       strobe_proc_n,
    input  logic       strobe_ctrl_n,
    input  logic       chip_en_n,
    input  logic       adv_n,
    output burst_cmd_t cmd
);

    always_comb begin
        cmd = decode_cmd(strobe_proc_n, strobe_ctrl_n, chip_en_n, adv_n);
    end

endmodule

// File: rtl/burst_seq_reg.sv
module burst_seq_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_t        cmd,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [CNT_W-1:0]  cnt_q
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (cmd.load) begin
            base_q <= addr_in;
            cnt_q  <= '0;
        end else if (cmd.step) begin
            cnt_q  <= cnt_q + CNT_ONE;
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  cnt,
    input  burst_order_e      order,
    output logic [ADDR_W-1:0] addr
);

    localparam int UP_W = ADDR_W - CNT_W;

    logic [CNT_W-1:0] low_lin;
    logic [CNT_W-1:0] low_xor;

    assign low_lin = base[CNT_W-1:0] + cnt;

    for (genvar i = 0; i < CNT_W; i++) begin : g_xor
        assign low_xor[i] = base[i] ^ cnt[i];
    end

    always_comb begin
        addr[ADDR_W-1:CNT_W] = base[ADDR_W-1:CNT_W];
        addr[CNT_W-1:0]      = (order == ORD_XOR) ? low_xor : low_lin;
    end

    if (UP_W < 1) begin : g_bad_width
        initial $display("burst_order_map: ADDR_W must exceed CNT_W");
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strobe_proc_n,
    input  logic              strobe_ctrl_n,
    input  logic              chip_en_n,
    input  logic              adv_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] addr_out
);

    burst_cmd_t        cmd;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    burst_order_e      order;

    assign order = burst_order_e'(order_sel);

    burst_cmd_dec u_dec (
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .cmd           (cmd)
    );

    burst_seq_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .addr_in (addr_in),
        .base_q  (base_q),
        .cnt_q   (cnt_q)
    );

    burst_order_map #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_map (
        .base  (base_q),
        .cnt   (cnt_q),
        .order (order),
        .addr  (addr_out)
    );

endmodule

// File: rtl/burst_addr_chk.sv
module burst_addr_chk #(
    parameter int ADDR_W = 17,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_in,
    input logic              strobe_proc_n,
    input logic              strobe_ctrl_n,
    input logic              chip_en_n,
    input logic              adv_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_out
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic accepted;
    assign accepted = !strobe_ctrl_n || (!strobe_proc_n && !chip_en_n);

    AST_LOAD_CTRL: assert property (@(posedge clk) disable iff (rst)
        !strobe_ctrl_n |=> addr_out == $past(addr_in)); // R2

    AST_LOAD_PROC: assert property (@(posedge clk) disable iff (rst)
        (!strobe_proc_n && !chip_en_n) |=> addr_out == $past(addr_in)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!accepted && adv_n) |=>
            (order_sel != $past(order_sel)) || $stable(addr_out)); // R10

    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
        !accepted |=> $stable(addr_out[ADDR_W-1:CNT_W])); // R7

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!accepted && !adv_n && !order_sel) |=>
            ($past(order_sel) != order_sel) ||
            (addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + ONE)); // R6

endmodule

bind burst_addr_gen burst_addr_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic [16:0] addr_in;
    logic        strobe_proc_n;
    logic        strobe_ctrl_n;
    logic        chip_en_n;
    logic        adv_n;
    logic        order_sel;
    logic [16:0] addr_out;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [16:0] m_base;
    logic [1:0]  m_cnt;

    always #10 clk = ~clk;

    burst_addr_gen u0 (
        .clk           (clk),
        .rst           (rst),
        .addr_in       (addr_in),
        .strobe_proc_n (strobe_proc_n),
        .strobe_ctrl_n (strobe_ctrl_n),
        .chip_en_n     (chip_en_n),
        .adv_n         (adv_n),
        .order_sel     (order_sel),
        .addr_out      (addr_out)
    );

    function automatic logic [16:0] expect_addr();
        logic [1:0] lo;
        lo = order_sel ? (m_base[1:0] ^ m_cnt) : 2'((m_base[1:0] + m_cnt) % 4);
        return {m_base[16:2], lo};
    endfunction

    task automatic check(input string req, input logic [16:0] exp);
        tests++;
        if (addr_out !== exp) begin
            fails++;
            $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
        end
    endtask

    // one clock: apply inputs, update the model per the requirements, wait past the edge
    task automatic cyc(input logic pn, input logic cn, input logic en,
                       input logic an, input logic [16:0] a);
        strobe_proc_n = pn;
        strobe_ctrl_n = cn;
        chip_en_n     = en;
        adv_n         = an;
        addr_in       = a;
        if (!cn || (!pn && !en)) begin
            m_base = a;
            m_cnt  = 2'd0;
        end else if (!an) begin
            m_cnt = m_cnt + 2'd1;
        end
        @(posedge clk);
        #2;
    endtask

    initial begin
        rst = 1'b1;
        strobe_proc_n = 1'b1;
        strobe_ctrl_n = 1'b1;
        chip_en_n = 1'b1;
        adv_n = 1'b1;
        order_sel = 1'b1;
        addr_in = '0;
        m_base = '0;
        m_cnt = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", 17'h0);
        rst = 1'b0;
        cyc(1, 1, 1, 1, 17'h1ABCD);
        check("R1", 17'h0);

        for (int md = 0; md < 2; md++) begin
            order_sel = md[0];
            cyc(1, 1, 1, 1, '0);
            for (int lo = 0; lo < 4; lo++) begin
                logic [16:0] start;
                start = {15'(17'h0A5C3 + lo * 4099 + md * 777), 2'(lo)};
                cyc(1, 0, 1, 1, start);            // controller strobe, enable off
                check("R2", start);
                for (int n = 1; n <= 4; n++) begin
                    cyc(1, 1, 1, 0, 17'h1FFFF);
                    check(md ? "R5" : "R6", expect_addr());
                    if (addr_out[16:2] !== start[16:2]) begin
                        fails++;
                        $display("FAIL R7: upper=%h expected=%h", addr_out[16:2], start[16:2]);
                    end
                    tests++;
                    if (n == 2) begin
                        cyc(1, 1, 0, 1, 17'h00000);
                        check("R10", expect_addr());
                    end
                end
                check("R8", start);
            end
        end

        order_sel = 1'b0;
        cyc(1, 1, 1, 1, '0);
        cyc(1, 0, 1, 1, 17'h12345);
        check("R2", 17'h12345);
        cyc(0, 1, 1, 1, 17'h0F0F2);                 // processor strobe, enable off
        check("R4", 17'h12345);
        cyc(0, 1, 0, 1, 17'h0F0F2);                 // processor strobe, enable on
        check("R3", 17'h0F0F2);
        cyc(1, 1, 1, 0, '0);
        cyc(1, 1, 1, 0, '0);
        check("R6", {15'(17'h0F0F2 >> 2), 2'd0});
        cyc(0, 1, 0, 0, 17'h13579);                 // strobe with advance
        check("R9", 17'h13579);
        cyc(1, 1, 1, 0, '0);
        cyc(1, 0, 0, 0, 17'h02468);
        check("R9", 17'h02468);
        cyc(1, 1, 1, 1, 17'h1FFFF);
        check("R10", 17'h02468);

        order_sel = 1'b1;
        cyc(1, 1, 1, 1, '0);
        cyc(0, 1, 0, 1, 17'h00003);
        check("R3", 17'h00003);
        cyc(1, 1, 1, 0, '0);
        check("R5", 17'h00002);
        cyc(1, 1, 1, 0, '0);
        check("R5", 17'h00001);
        cyc(1, 1, 1, 0, '0);
        check("R5", 17'h00000);

        rst = 1'b1;
        cyc(1, 1, 1, 1, '0);
        m_base = '0;
        m_cnt = '0;
        check("R1", 17'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule